// File: doc/BRIEF.md
# PWM Duty-Cycle Current Decoder

This block sits on the controller side of an isolated current sensor whose only data path is an active-low pulse-width output. A sampling strobe (the SYNC input) switches level once per measurement cycle. Each level period of SYNC is one cycle. Within each cycle the block counts, on a fast system clock, two things: how many clocks the sensor output is released high (the off time) and how many clocks the cycle lasts. When the next SYNC edge closes the cycle, the block turns the off-time ratio into a signed 16-bit code for the sensed input voltage.

The sensor encodes zero input as a 20% off ratio. The ratio falls as the input rises, so the conversion is `code = (2 - 10*D) * 32768`. This maps +250 mV (10%) to positive full scale and -250 mV (30%) to negative full scale. Cycles taken while SYNC is high and cycles taken while SYNC is low are tagged as two separate channels. Each channel has its own offset trim, because the sensor's two half-cycle paths can drift apart. An averaging mode outputs the mean of each result and the one before it, which cancels odd carrier harmonics under center-aligned modulation. A SYNC watchdog drops cycles that never close and reports loss of sync.

Both inputs pass through the same two-flop synchronizer, so their relative timing is kept. A serial divider needs about 40 clocks per result. This fits easily within the shortest cycle the block supports.

Top module: `pwmdec`

## Requirements
- R1: With P the cycle length and K the off-time count (clocks with `pwmIn` high), the result is `trunc(|2P-10K|*32768/P)`. The division truncates toward zero. The result is positive when 10K < 2P and negative otherwise. The channel's offset is then subtracted, and the value is saturated to the range -32768..32767.
- R2: `chanTag` is 1 for a cycle during which SYNC was high and 0 for a cycle during which SYNC was low. `offsetHigh` applies to tag 1 and `offsetLow` applies to tag 0.
- R3: If 25K < 2P (off ratio below 8%), the result is 0x7FFF and `rangeErr` is 1. If 25K > 8P (above 32%), the result is 0x8000 and `rangeErr` is 1. In both cases the offset has no effect. At exactly 8% or 32% the cycle is in range and `rangeErr` is 0.
- R4: When `avgEn` is 1, `sampleOut` is `floor((c + p)/2)`. Here c is the current value after offset and range handling, and p is the previous such value. The first result after reset or after a loss of sync is passed through unchanged.
- R5: `sampleValid` pulses for exactly one clock for each cycle that a SYNC edge opened and the next SYNC edge closed. No other pulses occur.
- R6: If a cycle reaches `timeoutLimit` clocks without a SYNC edge, `lossOfSync` rises and that cycle produces no result. The next SYNC edge clears `lossOfSync`, and the cycle that edge opens is measured normally.
- R7: After reset, `sampleOut`, `sampleValid`, `chanTag`, `rangeErr` and `lossOfSync` are all 0.
- R8: `sampleOut`, `chanTag` and `rangeErr` hold their values between valid pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Cycle strobe; each level is one measurement cycle |
| pwmIn | input | 1 | Sensor pulse output, high while released (off) |
| offsetHigh | input | 16 | Signed offset subtracted from SYNC-high cycles |
| offsetLow | input | 16 | Signed offset subtracted from SYNC-low cycles |
| avgEn | input | 1 | Average each result with the previous one |
| timeoutLimit | input | 16 | Cycle length in clocks that declares loss of sync |
| sampleOut | output | 16 | Signed current code |
| sampleValid | output | 1 | One-clock strobe for a new result |
| chanTag | output | 1 | SYNC level of the cycle the result came from |
| rangeErr | output | 1 | Off ratio of that cycle was outside 8%..32% |
| lossOfSync | output | 1 | No SYNC edge within the timeout |

## Verification
The assertions assume that every cycle lasts at least 64 clocks, so the serial divide always finishes before the next SYNC edge. They also assume that `timeoutLimit` is larger than the divide latency. Their checks on full-scale codes and on held outputs only make sense when the configuration ports stay constant across a cycle boundary. The stimulus drives cycles of 700 to 4000 clocks with alternating SYNC levels. It changes offsets and the averaging mode only between cycles. It crosses the timeout only with the single long cycle that is meant to trip it.

// File: rtl/pwmdec_pkg.sv
package pwmdec_pkg;

  // Strobes from the cycle controller to the datapath
  typedef struct packed {
    logic cycleEdge;  // a SYNC edge was seen this clock
    logic load;       // capture closed-cycle counts, start the divide
    logic step;       // one divider iteration
    logic emit;       // register the finished result
    logic dropHist;   // forget the averaging history
  } pwmdec_strb_t;

endpackage

// File: rtl/pwmdec_sync.sv
module pwmdec_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/pwmdec_ctrl.sv
module pwmdec_ctrl
  import pwmdec_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int STEPS = 35
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncS,
  input  logic [CNT_W-1:0] timeoutLimit,
  output pwmdec_strb_t     strb,
  output logic [CNT_W-1:0] periodCnt,
  output logic             prevLevel,
  output logic             lossOfSync
);

  localparam int STEP_W = $clog2(STEPS + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_EMIT} state_t;

  state_t            state;
  logic              syncPrev;
  logic              armed;
  logic              syncEdge;
  logic              closeOk;
  logic [STEP_W-1:0] stepCnt;

  assign syncEdge  = syncS ^ syncPrev;
  assign closeOk   = syncEdge & armed & ~lossOfSync;
  assign prevLevel = syncPrev;

  // Cycle length counter and sync watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev   <= 1'b0;
      periodCnt  <= '0;
      armed      <= 1'b0;
      lossOfSync <= 1'b0;
    end else begin
      syncPrev <= syncS;
      if (syncEdge) begin
        periodCnt  <= CNT_W'(1);
        armed      <= 1'b1;
        lossOfSync <= 1'b0;
      end else if (periodCnt >= timeoutLimit) begin
        armed      <= 1'b0;
        lossOfSync <= 1'b1;
      end else begin
        periodCnt <= periodCnt + CNT_W'(1);
      end
    end
  end

  // Conversion sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (closeOk) begin
          state   <= ST_DIV;
          stepCnt <= '0;
        end
        ST_DIV: begin
          stepCnt <= stepCnt + STEP_W'(1);
          if (stepCnt == LAST_STEP) state <= ST_EMIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.cycleEdge = syncEdge;
    strb.load      = closeOk && (state == ST_IDLE);
    strb.step      = (state == ST_DIV);
    strb.emit      = (state == ST_EMIT) && !lossOfSync;
    strb.dropHist  = lossOfSync;
  end

endmodule

// File: rtl/pwmdec_dp.sv
module pwmdec_dp
  import pwmdec_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwmS,
  input  pwmdec_strb_t     strb,
  input  logic [CNT_W-1:0] periodIn,
  input  logic             prevLevel,
  input  logic [OUT_W-1:0] offsetHigh,
  input  logic [OUT_W-1:0] offsetLow,
  input  logic             avgEn,
  output logic [OUT_W-1:0] sampleOut,
  output logic             sampleValid,
  output logic             chanTag,
  output logic             rangeErr
);

  localparam int MW    = CNT_W + 5;              // room for 25*K
  localparam int MAG_W = CNT_W + 4;              // room for 10*K
  localparam int NUM_W = MAG_W + OUT_W - 1;      // magnitude * 2^(OUT_W-1)
  localparam int Q_W   = OUT_W + 3;              // quotient reaches 8 * 2^(OUT_W-1)
  localparam int D_W   = Q_W + 2;
  localparam logic signed [D_W-1:0] POS_LIM = D_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [D_W-1:0] NEG_LIM = -POS_LIM - D_W'(1);

  logic [CNT_W-1:0] offCnt;
  logic [CNT_W-1:0] denReg;
  logic [CNT_W-1:0] remReg;
  logic [NUM_W-1:0] quoReg;
  logic             negReg, lowReg, highReg, tagReg;
  logic [OUT_W-1:0] prevVal;
  logic             prevValid;

  // Off-time counter, restarted by every SYNC edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               offCnt <= '0;
    else if (strb.cycleEdge) offCnt <= CNT_W'(pwmS);
    else                     offCnt <= offCnt + CNT_W'(pwmS);
  end

  // Numerator and range classification of the closed cycle
  logic [MW-1:0] perExt, offExt, twoP, eightP, tenK, quarterK;
  logic          negNow;
  logic [MW-1:0] magNow;

  always_comb begin
    perExt   = MW'(periodIn);
    offExt   = MW'(offCnt);
    twoP     = perExt << 1;
    eightP   = perExt << 3;
    tenK     = (offExt << 3) + (offExt << 1);
    quarterK = (offExt << 4) + (offExt << 3) + offExt;
    negNow   = tenK > twoP;
    magNow   = negNow ? (tenK - twoP) : (twoP - tenK);
  end

  // Restoring divider, one quotient bit per step
  logic [CNT_W:0] remShift;
  assign remShift = {remReg, quoReg[NUM_W-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      denReg  <= '0;
      remReg  <= '0;
      quoReg  <= '0;
      negReg  <= 1'b0;
      lowReg  <= 1'b0;
      highReg <= 1'b0;
      tagReg  <= 1'b0;
    end else if (strb.load) begin
      denReg  <= periodIn;
      remReg  <= '0;
      quoReg  <= {magNow[MAG_W-1:0], {(OUT_W-1){1'b0}}};
      negReg  <= negNow;
      lowReg  <= quarterK < twoP;
      highReg <= quarterK > eightP;
      tagReg  <= prevLevel;
    end else if (strb.step) begin
      if (remShift >= {1'b0, denReg}) begin
        remReg <= CNT_W'(remShift - {1'b0, denReg});
        quoReg <= {quoReg[NUM_W-2:0], 1'b1};
      end else begin
        remReg <= remShift[CNT_W-1:0];
        quoReg <= {quoReg[NUM_W-2:0], 1'b0};
      end
    end
  end

  // Sign, channel offset, saturation, range override, averaging
  logic [Q_W-1:0]          qMag;
  logic signed [Q_W:0]     rawVal;
  logic [OUT_W-1:0]        offSel;
  logic signed [D_W-1:0]   diff;
  logic [OUT_W-1:0]        corr;
  logic [OUT_W-1:0]        avgBase;
  logic signed [OUT_W:0]   pairSum;
  logic [OUT_W-1:0]        outVal;

  always_comb begin
    qMag    = quoReg[Q_W-1:0];
    rawVal  = negReg ? -$signed({1'b0, qMag}) : $signed({1'b0, qMag});
    offSel  = tagReg ? offsetHigh : offsetLow;
    diff    = $signed({rawVal[Q_W], rawVal})
            - $signed({{(D_W-OUT_W){offSel[OUT_W-1]}}, offSel});
    if (lowReg)              corr = {1'b0, {(OUT_W-1){1'b1}}};
    else if (highReg)        corr = {1'b1, {(OUT_W-1){1'b0}}};
    else if (diff > POS_LIM) corr = {1'b0, {(OUT_W-1){1'b1}}};
    else if (diff < NEG_LIM) corr = {1'b1, {(OUT_W-1){1'b0}}};
    else                     corr = diff[OUT_W-1:0];
    avgBase = prevValid ? prevVal : corr;
    pairSum = $signed({corr[OUT_W-1], corr}) + $signed({avgBase[OUT_W-1], avgBase});
    outVal  = avgEn ? pairSum[OUT_W:1] : corr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
      chanTag     <= 1'b0;
      rangeErr    <= 1'b0;
      prevVal     <= '0;
      prevValid   <= 1'b0;
    end else begin
      sampleValid <= strb.emit;
      if (strb.emit) begin
        sampleOut <= outVal;
        chanTag   <= tagReg;
        rangeErr  <= lowReg | highReg;
        prevVal   <= corr;
        prevValid <= 1'b1;
      end else if (strb.dropHist) begin
        prevValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwmdec.sv
module pwmdec
  import pwmdec_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int OUT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic             pwmIn,
  input  logic [OUT_W-1:0] offsetHigh,
  input  logic [OUT_W-1:0] offsetLow,
  input  logic             avgEn,
  input  logic [CNT_W-1:0] timeoutLimit,
  output logic [OUT_W-1:0] sampleOut,
  output logic             sampleValid,
  output logic             chanTag,
  output logic             rangeErr,
  output logic             lossOfSync
);

  localparam int DIV_STEPS = CNT_W + 4 + OUT_W - 1;

  logic [1:0]       synced;
  pwmdec_strb_t     strb;
  logic [CNT_W-1:0] periodCnt;
  logic             prevLevel;

  pwmdec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({syncIn, pwmIn}),
    .dout (synced)
  );

  pwmdec_ctrl #(.CNT_W(CNT_W), .STEPS(DIV_STEPS)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .syncS        (synced[1]),
    .timeoutLimit (timeoutLimit),
    .strb         (strb),
    .periodCnt    (periodCnt),
    .prevLevel    (prevLevel),
    .lossOfSync   (lossOfSync)
  );

  pwmdec_dp #(.CNT_W(CNT_W), .OUT_W(OUT_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pwmS        (synced[0]),
    .strb        (strb),
    .periodIn    (periodCnt),
    .prevLevel   (prevLevel),
    .offsetHigh  (offsetHigh),
    .offsetLow   (offsetLow),
    .avgEn       (avgEn),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid),
    .chanTag     (chanTag),
    .rangeErr    (rangeErr)
  );

endmodule

// File: rtl/pwmdec_chk.sv
module pwmdec_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             avgEn,
  input logic [OUT_W-1:0] sampleOut,
  input logic             sampleValid,
  input logic             chanTag,
  input logic             rangeErr,
  input logic             lossOfSync
);

  localparam logic [OUT_W-1:0] FS_POS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] FS_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid); // R5

  AST_QUIET_IN_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    lossOfSync |-> !sampleValid); // R6

  AST_RANGE_FULLSCALE: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && rangeErr && !avgEn && !$past(avgEn))
      |-> (sampleOut == FS_POS || sampleOut == FS_NEG)); // R3

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(sampleOut) && $stable(chanTag) && $stable(rangeErr))); // R8

endmodule

bind pwmdec pwmdec_chk #(.OUT_W(OUT_W)) i_pwmdec_chk (
  .clk         (clk),
  .rstN        (rstN),
  .avgEn       (avgEn),
  .sampleOut   (sampleOut),
  .sampleValid (sampleValid),
  .chanTag     (chanTag),
  .rangeErr    (rangeErr),
  .lossOfSync  (lossOfSync)
);

// File: tb/test_pwmdec.sv
module test_pwmdec;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        syncIn = 1'b0;
  logic        pwmIn = 1'b0;
  logic [15:0] offsetHigh = 16'd100;
  logic [15:0] offsetLow = 16'hFFCE; // -50
  logic        avgEn = 1'b0;
  logic [15:0] timeoutLimit = 16'd3000;
  logic [15:0] sampleOut;
  logic        sampleValid, chanTag, rangeErr, lossOfSync;

  always #2 clk = ~clk; // 250 MHz

  pwmdec i_pwmdec (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .pwmIn(pwmIn),
    .offsetHigh(offsetHigh), .offsetLow(offsetLow), .avgEn(avgEn),
    .timeoutLimit(timeoutLimit), .sampleOut(sampleOut),
    .sampleValid(sampleValid), .chanTag(chanTag), .rangeErr(rangeErr),
    .lossOfSync(lossOfSync)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Stimulus and expected-result vectors: level, period, off clocks
  localparam int NV = 10;
  localparam int V_LVL [NV] = '{1, 0, 1, 0, 1, 0, 1, 0, 1, 0};
  localparam int V_P   [NV] = '{1000, 1000, 800, 800, 1000, 1000, 1000, 1000, 1200, 700};
  localparam int V_K   [NV] = '{200, 150, 80, 240, 79, 321, 80, 320, 250, 133};

  // Expectation queue filled by the driver, drained by the monitor
  int expVal [64];
  int expTag [64];
  int expRng [64];
  int expReq [64]; // 1: R1, 3: R3, 4: R4
  int wrIdx = 0;
  int rdIdx = 0;
  int lastOut = 0;

  // Model state
  bit pendValid = 1'b0;
  int pendLvl, pendP, pendK;
  bit mPrevValid = 1'b0;
  int mPrev = 0;

  function automatic int sext16(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  task automatic pushExpected();
    longint num, mag, q, raw, d;
    int corr, outv, rng;
    num = 2 * longint'(pendP) - 10 * longint'(pendK);
    mag = (num < 0) ? -num : num;
    q   = (mag * 32768) / pendP;
    raw = (num < 0) ? -q : q;
    d   = raw - (pendLvl ? sext16(offsetHigh) : sext16(offsetLow));
    if (d > 32767) d = 32767;
    if (d < -32768) d = -32768;
    corr = int'(d);
    rng  = 0;
    if (25 * pendK < 2 * pendP) begin corr = 32767; rng = 1; end
    else if (25 * pendK > 8 * pendP) begin corr = -32768; rng = 1; end
    outv = corr;
    if (avgEn && mPrevValid) outv = (corr + mPrev) >>> 1;
    mPrev = corr;
    mPrevValid = 1'b1;
    expVal[wrIdx] = outv;
    expTag[wrIdx] = pendLvl;
    expRng[wrIdx] = rng;
    expReq[wrIdx] = avgEn ? 4 : (rng ? 3 : 1);
    wrIdx++;
  endtask

  task automatic runCycle(input int lvl, input int p, input int k);
    if (pendValid) pushExpected();
    pendLvl = lvl; pendP = p; pendK = k;
    pendValid = (p < int'(timeoutLimit));
    for (int i = 0; i < p; i++) begin
      syncIn = lvl[0];
      pwmIn  = (i < k);
      @(negedge clk);
    end
    if (p >= int'(timeoutLimit)) begin
      check("R6 loss raised", int'(lossOfSync), 1);
      mPrevValid = 1'b0;
    end
  endtask

  // Monitor: compare every strobe with the next queued expectation
  always @(negedge clk) begin
    if (rstN && sampleValid) begin
      if (rdIdx >= wrIdx) begin
        check("R5 unexpected strobe", 1, 0);
      end else begin
        case (expReq[rdIdx])
          3:       check("R3 sample", sext16(sampleOut), expVal[rdIdx]);
          4:       check("R4 sample", sext16(sampleOut), expVal[rdIdx]);
          default: check("R1 sample", sext16(sampleOut), expVal[rdIdx]);
        endcase
        check("R2 tag", int'(chanTag), expTag[rdIdx]);
        check("R3 flag", int'(rangeErr), expRng[rdIdx]);
        lastOut = sext16(sampleOut);
        rdIdx++;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R7: reset state while reset is held and just after release
    check("R7 sampleOut", int'(sampleOut), 0);
    check("R7 sampleValid", int'(sampleValid), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check("R7 lossOfSync", int'(lossOfSync), 0);
    check("R7 rangeErr", int'(rangeErr), 0);
    check("R7 chanTag", int'(chanTag), 0);

    // Table walk: offsets fixed, averaging off
    for (int v = 0; v < NV; v++) runCycle(V_LVL[v], V_P[v], V_K[v]);

    // R4: averaging switched on between cycles
    avgEn = 1'b1;
    runCycle(1, 1000, 150);
    runCycle(0, 1000, 250);
    runCycle(1, 1000, 100);
    runCycle(0, 900, 200);

    // R8: output held mid-cycle equals the last strobed value
    check("R8 hold", sext16(sampleOut), lastOut);

    // R6: one cycle longer than the timeout, then recovery
    runCycle(1, 4000, 800);
    runCycle(0, 1000, 200);
    check("R6 loss cleared", int'(lossOfSync), 0);
    runCycle(1, 1000, 100);
    runCycle(0, 1000, 300);

    repeat (100) @(negedge clk);
    check("R8 hold end", sext16(sampleOut), lastOut);
    check("R5 all strobes seen", rdIdx, wrIdx);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule